// File: doc/BRIEF.md
# Render Pass Dual-Queue Dispatcher

The block takes render-pass jobs and shares a pool of shader-core slots between their two halves. Each submitted job carries a pass identifier and two work-item counts. One count is for the geometry/compute piece and one is for the fragment piece. Each piece is placed in its own in-order issue queue. Each queue breaks its head piece into single work items and hands them to idle cores. A core reports that an item is finished with a one-cycle done pulse.

The two queues run side by side. Geometry items of a later pass can therefore occupy cores while fragment items of an earlier pass are still in flight. The only coupling is that a fragment piece stays blocked until every geometry item of its own pass has been issued and has reported done. When the last fragment item of a pass retires, the block emits a one-cycle completion pulse that carries the pass identifier. Passes complete in the order they were submitted.

Top module: `rpd_dispatch`

## Requirements
- R1: A job is accepted on a clock edge where `sub_valid_i` and `sub_ready_o` are both high. `sub_ready_o` is low while either queue already holds QDEPTH (default 4) pieces.
- R2: For each accepted job, exactly `sub_geo_cnt_i` pulses with `disp_frag_o[c]`=0 and exactly `sub_frag_cnt_i` pulses with `disp_frag_o[c]`=1 appear on `disp_valid_o`. Each pulse carries the job's pass id on `disp_pass_o[c*PASS_W +: PASS_W]`.
- R3: No item is dispatched to a core that has received an item and has not yet pulsed `core_done_i` for it.
- R4: No fragment item of a pass is dispatched while any geometry item of that pass is unissued or outstanding.
- R5: Geometry items of a later pass are dispatched while fragment items of an earlier pass are still outstanding.
- R6: Each queue dispatches at most one item per clock. When both queues want the same single idle core, the geometry queue gets it.
- R7: The core search starts at the core after the last granted one. From reset, with all cores idle, a single geometry piece of 4 items lands on cores 0, 1, 2 and 3 in that order on consecutive cycles.
- R8: `pass_done_o` pulses once per job with `pass_done_id_o` equal to its pass id. The pulse comes after the job's last fragment item is done, and the pulses follow submission order.
- R9: A `core_done_i` pulse on a core that holds no item has no effect: later jobs still dispatch their full counts and complete.
- R10: After reset, `sub_ready_o` is 1, and `disp_valid_o` and `pass_done_o` are 0.
- R11: A piece whose count is 0 dispatches nothing and still counts as complete. A job with a zero fragment count still produces its `pass_done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_valid_i | input | 1 | Job submit valid |
| sub_ready_o | output | 1 | Both queues can take a job |
| sub_pass_i | input | PASS_W | Pass identifier of the job |
| sub_geo_cnt_i | input | CNT_W | Geometry work-item count |
| sub_frag_cnt_i | input | CNT_W | Fragment work-item count |
| disp_valid_o | output | N_CORES | One-cycle dispatch pulse per core |
| disp_frag_o | output | N_CORES | Piece type of the dispatch, 1 = fragment |
| disp_pass_o | output | N_CORES*PASS_W | Pass id of the dispatch, per core |
| core_done_i | input | N_CORES | One-cycle item-finished pulse per core |
| pass_done_o | output | 1 | Pass fully retired |
| pass_done_id_o | output | PASS_W | Id of the retired pass |

## Verification
The stimulus first submits jobs while all cores are held busy. This pattern exposes the full-queue backpressure and the round-robin start order, and it shows that nothing is dispatched into occupied cores. A table of jobs is then run with cores of different latencies. The table mixes large and small counts with zero geometry and zero fragment counts, which separates correct per-pass gating and ordered completion from designs that leak fragment work early or drop empty pieces. A final spurious done on idle cores followed by a fresh job tells apart a design that masks such pulses from one whose outstanding count underflows.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic {
    PIECE_GEO  = 1'b0,
    PIECE_FRAG = 1'b1
  } piece_e;
endpackage

// File: rtl/rpd_pick.sv
// First available core at or after start_i, wrapping.
module rpd_pick #(
  parameter int N_CORES = 4,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic [N_CORES-1:0] avail_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N_CORES; k++) begin
      int j;
      j = (int'(start_i) + k) % N_CORES;
      if (!hit_o && avail_i[j]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/rpd_queue.sv
// In-order piece queue; head is split into items, popped once fully retired.
module rpd_queue #(
  parameter int DEPTH   = 4,
  parameter int PASS_W  = 4,
  parameter int CNT_W   = 8,
  parameter int N_CORES = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int USE_W = $clog2(DEPTH + 1),
  localparam int OUT_W = $clog2(N_CORES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PASS_W-1:0] push_pass_i,
  input  logic [CNT_W-1:0]  push_cnt_i,
  output logic              full_o,
  input  logic              gate_i,
  input  logic              grant_i,
  input  logic [OUT_W-1:0]  done_num_i,
  output logic              want_o,
  output logic [PASS_W-1:0] head_pass_o,
  output logic              retire_o
);
  logic [PASS_W-1:0] pass_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [USE_W-1:0]  used;
  logic [CNT_W-1:0]  issued;
  logic [OUT_W-1:0]  outst;
  logic              head_valid;

  assign head_valid  = used != '0;
  assign full_o      = used == USE_W'(DEPTH);
  assign head_pass_o = pass_q[rd_ptr];
  assign want_o      = head_valid && gate_i && (issued != cnt_q[rd_ptr]);
  assign retire_o    = head_valid && gate_i && (issued == cnt_q[rd_ptr]) && (outst == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
      issued <= '0;
      outst  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pass_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      if (push_i) begin
        pass_q[wr_ptr] <= push_pass_i;
        cnt_q[wr_ptr]  <= push_cnt_i;
        wr_ptr         <= PTR_W'((int'(wr_ptr) + 1) % DEPTH);
      end
      if (retire_o) begin
        rd_ptr <= PTR_W'((int'(rd_ptr) + 1) % DEPTH);
        issued <= '0;
      end else if (grant_i) begin
        issued <= issued + CNT_W'(1);
      end
      used  <= used + USE_W'(push_i) - USE_W'(retire_o);
      outst <= outst + OUT_W'(grant_i) - done_num_i;
    end
  end
endmodule

// File: rtl/rpd_dispatch.sv
module rpd_dispatch
  import rpd_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int QDEPTH  = 4,
  parameter int PASS_W  = 4,
  parameter int CNT_W   = 8,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int OUT_W = $clog2(N_CORES + 1),
  localparam int CR_W  = $clog2(QDEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sub_valid_i,
  output logic                       sub_ready_o,
  input  logic [PASS_W-1:0]          sub_pass_i,
  input  logic [CNT_W-1:0]           sub_geo_cnt_i,
  input  logic [CNT_W-1:0]           sub_frag_cnt_i,
  output logic [N_CORES-1:0]         disp_valid_o,
  output logic [N_CORES-1:0]         disp_frag_o,
  output logic [N_CORES*PASS_W-1:0]  disp_pass_o,
  input  logic [N_CORES-1:0]         core_done_i,
  output logic                       pass_done_o,
  output logic [PASS_W-1:0]          pass_done_id_o
);
  logic [N_CORES-1:0] busy, kind_frag, done_eff;
  logic [N_CORES-1:0] geo_mask, frag_mask, frag_avail;
  logic [IDX_W-1:0]   ptr, geo_idx, frag_idx;
  logic [CR_W-1:0]    credits;
  logic               push, geo_full, frag_full;
  logic               geo_want, frag_want, geo_hit, frag_hit;
  logic               geo_grant, frag_grant, geo_retire, frag_retire;
  logic [PASS_W-1:0]  geo_pass, frag_pass;
  logic [OUT_W-1:0]   geo_done_num, frag_done_num;

  assign sub_ready_o   = !geo_full && !frag_full;
  assign push          = sub_valid_i && sub_ready_o;
  assign done_eff      = core_done_i & busy;   // stray done pulses dropped
  assign geo_done_num  = OUT_W'($countones(done_eff & ~kind_frag));
  assign frag_done_num = OUT_W'($countones(done_eff & kind_frag));

  rpd_queue #(.DEPTH(QDEPTH), .PASS_W(PASS_W), .CNT_W(CNT_W), .N_CORES(N_CORES)) u_geo_q (
    .clk_i, .rst_ni, .push_i(push), .push_pass_i(sub_pass_i), .push_cnt_i(sub_geo_cnt_i),
    .full_o(geo_full), .gate_i(1'b1), .grant_i(geo_grant), .done_num_i(geo_done_num),
    .want_o(geo_want), .head_pass_o(geo_pass), .retire_o(geo_retire)
  );

  // Fragment head may run only while a finished-geometry credit exists.
  rpd_queue #(.DEPTH(QDEPTH), .PASS_W(PASS_W), .CNT_W(CNT_W), .N_CORES(N_CORES)) u_frag_q (
    .clk_i, .rst_ni, .push_i(push), .push_pass_i(sub_pass_i), .push_cnt_i(sub_frag_cnt_i),
    .full_o(frag_full), .gate_i(credits != '0), .grant_i(frag_grant), .done_num_i(frag_done_num),
    .want_o(frag_want), .head_pass_o(frag_pass), .retire_o(frag_retire)
  );

  rpd_pick #(.N_CORES(N_CORES)) u_geo_pick (
    .avail_i(~busy), .start_i(ptr), .hit_o(geo_hit), .idx_o(geo_idx)
  );

  assign geo_grant  = geo_want && geo_hit;
  assign geo_mask   = geo_grant ? (N_CORES'(1) << geo_idx) : '0;
  assign frag_avail = ~busy & ~geo_mask;      // geometry wins ties

  rpd_pick #(.N_CORES(N_CORES)) u_frag_pick (
    .avail_i(frag_avail), .start_i(ptr), .hit_o(frag_hit), .idx_o(frag_idx)
  );

  assign frag_grant = frag_want && frag_hit;
  assign frag_mask  = frag_grant ? (N_CORES'(1) << frag_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy           <= '0;
      kind_frag      <= '0;
      ptr            <= '0;
      credits        <= '0;
      disp_valid_o   <= '0;
      disp_frag_o    <= '0;
      disp_pass_o    <= '0;
      pass_done_o    <= 1'b0;
      pass_done_id_o <= '0;
    end else begin
      busy         <= (busy & ~done_eff) | geo_mask | frag_mask;
      kind_frag    <= (kind_frag & ~geo_mask) | frag_mask;
      credits      <= credits + CR_W'(geo_retire) - CR_W'(frag_retire);
      disp_valid_o <= geo_mask | frag_mask;
      disp_frag_o  <= frag_mask;
      for (int c = 0; c < N_CORES; c++) begin
        if (geo_mask[c])       disp_pass_o[c*PASS_W +: PASS_W] <= geo_pass;
        else if (frag_mask[c]) disp_pass_o[c*PASS_W +: PASS_W] <= frag_pass;
        else                   disp_pass_o[c*PASS_W +: PASS_W] <= '0;
      end
      if (frag_grant)     ptr <= IDX_W'((int'(frag_idx) + 1) % N_CORES);
      else if (geo_grant) ptr <= IDX_W'((int'(geo_idx) + 1) % N_CORES);
      pass_done_o <= frag_retire;
      if (frag_retire) pass_done_id_o <= frag_pass;
    end
  end
endmodule

// File: rtl/rpd_dispatch_chk.sv
module rpd_dispatch_chk #(
  parameter int N_CORES = 4,
  parameter int PASS_W  = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_CORES-1:0]        disp_valid_o,
  input logic [N_CORES-1:0]        disp_frag_o,
  input logic [N_CORES*PASS_W-1:0] disp_pass_o,
  input logic [N_CORES-1:0]        core_done_i,
  input logic                      pass_done_o,
  input logic [PASS_W-1:0]         pass_done_id_o
);
  // Port-level shadow of core occupancy.
  logic [N_CORES-1:0] sh_busy, sh_frag;
  logic [PASS_W-1:0]  sh_pass [N_CORES];
  logic               frag_early, done_early;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_busy <= '0;
      sh_frag <= '0;
      for (int c = 0; c < N_CORES; c++) sh_pass[c] <= '0;
    end else begin
      sh_busy <= (sh_busy | disp_valid_o) & ~core_done_i;
      for (int c = 0; c < N_CORES; c++) begin
        if (disp_valid_o[c]) begin
          sh_frag[c] <= disp_frag_o[c];
          sh_pass[c] <= disp_pass_o[c*PASS_W +: PASS_W];
        end
      end
    end
  end

  always_comb begin
    frag_early = 1'b0;
    done_early = 1'b0;
    for (int c = 0; c < N_CORES; c++) begin
      for (int d = 0; d < N_CORES; d++) begin
        if (disp_valid_o[c] && disp_frag_o[c] && sh_busy[d] && !sh_frag[d] &&
            sh_pass[d] == disp_pass_o[c*PASS_W +: PASS_W])
          frag_early = 1'b1;
      end
      if (pass_done_o && sh_busy[c] && sh_frag[c] && sh_pass[c] == pass_done_id_o)
        done_early = 1'b1;
    end
  end

  a_r3_no_busy_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o & sh_busy) == '0);
  a_r4_frag_after_geo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frag_early);
  a_r6_one_geo_per_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_valid_o & ~disp_frag_o) <= 1);
  a_r6_one_frag_per_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_valid_o & disp_frag_o) <= 1);
  a_r8_done_after_frag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_early);
endmodule

bind rpd_dispatch rpd_dispatch_chk #(.N_CORES(N_CORES), .PASS_W(PASS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_valid_o(disp_valid_o), .disp_frag_o(disp_frag_o),
  .disp_pass_o(disp_pass_o), .core_done_i(core_done_i), .pass_done_o(pass_done_o),
  .pass_done_id_o(pass_done_id_o)
);

// File: tb/rpd_dispatch_test.sv
module rpd_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int PW = 4;
  localparam int CW = 8;
  localparam int NP = 16;
  localparam int NTAB = 6;
  // {pass, geo count, frag count}
  localparam logic [19:0] TAB [NTAB] = '{
    {4'd5, 8'd3, 8'd2}, {4'd6, 8'd5, 8'd4}, {4'd7, 8'd0, 8'd2},
    {4'd8, 8'd2, 8'd0}, {4'd9, 8'd7, 8'd6}, {4'd10, 8'd1, 8'd1}
  };

  logic clk = 0, rst_n = 0;
  logic sub_valid = 0;
  logic [PW-1:0] sub_pass = '0;
  logic [CW-1:0] sub_geo = '0, sub_frag = '0;
  logic sub_ready, pass_done;
  logic [PW-1:0] pass_done_id;
  logic [NC-1:0] disp_valid, disp_frag, done_r = '0, spur = '0;
  logic [NC*PW-1:0] disp_pass;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpd_dispatch #(.N_CORES(NC), .QDEPTH(4), .PASS_W(PW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sub_valid_i(sub_valid), .sub_ready_o(sub_ready),
    .sub_pass_i(sub_pass), .sub_geo_cnt_i(sub_geo), .sub_frag_cnt_i(sub_frag),
    .disp_valid_o(disp_valid), .disp_frag_o(disp_frag), .disp_pass_o(disp_pass),
    .core_done_i(done_r | spur), .pass_done_o(pass_done), .pass_done_id_o(pass_done_id)
  );

  int n_chk = 0, n_bad = 0;
  bit stall = 0, finished = 0;
  int exp_geo [NP], exp_frag [NP], gcnt [NP], fcnt [NP], gout [NP];
  int sub_order [32], done_order [32], n_sub = 0, n_done = 0;
  int first_cores [4], n_disp = 0;
  int viol_busy = 0, viol_gate = 0, viol_rate = 0;
  bit overlap = 0;
  bit sh_busy [NC], sh_frag [NC];
  int sh_pass [NC], tmr [NC];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  // Core model and port monitor.
  always @(negedge clk) begin
    int ng, nf;
    ng = 0; nf = 0;
    for (int c = 0; c < NC; c++) begin
      if (done_r[c] && sh_busy[c]) begin
        sh_busy[c] = 0;
        if (!sh_frag[c]) gout[sh_pass[c]]--;
      end
    end
    done_r = '0;
    for (int c = 0; c < NC; c++) begin
      if (disp_valid[c]) begin
        int p;
        p = int'(disp_pass[c*PW +: PW]);
        if (sh_busy[c]) viol_busy++;
        if (n_disp < 4) first_cores[n_disp] = c;
        n_disp++;
        if (disp_frag[c]) begin
          nf++;
          fcnt[p]++;
          if (gcnt[p] != exp_geo[p] || gout[p] != 0) viol_gate++;
        end else begin
          ng++;
          gcnt[p]++;
          gout[p]++;
          for (int d = 0; d < NC; d++)
            if (sh_busy[d] && sh_frag[d] && sh_pass[d] != p) overlap = 1;
        end
        sh_busy[c] = 1;
        sh_frag[c] = disp_frag[c];
        sh_pass[c] = p;
        tmr[c] = c;
      end else if (sh_busy[c] && !stall) begin
        if (tmr[c] == 0) done_r[c] = 1'b1;
        else tmr[c]--;
      end
    end
    if (ng > 1 || nf > 1) viol_rate++;
    if (pass_done) begin
      done_order[n_done] = int'(pass_done_id);
      n_done++;
    end
  end

  task automatic submit(input int p, input int g, input int f);
    bit acc;
    exp_geo[p] = g;
    exp_frag[p] = f;
    sub_order[n_sub] = p;
    n_sub++;
    @(negedge clk);
    sub_valid = 1; sub_pass = PW'(p); sub_geo = CW'(g); sub_frag = CW'(f);
    forever begin
      acc = sub_ready;
      @(negedge clk);
      if (acc) break;
    end
    sub_valid = 0;
  endtask

  task automatic drain();
    while (n_done < n_sub) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      exp_geo[i] = 0; exp_frag[i] = 0; gcnt[i] = 0; fcnt[i] = 0; gout[i] = 0;
    end
    for (int c = 0; c < NC; c++) begin
      sh_busy[c] = 0; sh_frag[c] = 0; sh_pass[c] = 0; tmr[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(sub_ready == 1'b1, "R10 ready after reset", int'(sub_ready), 1);
    chk(disp_valid == '0, "R10 no dispatch in reset", int'(disp_valid), 0);
    chk(pass_done == 1'b0, "R10 no pass done in reset", int'(pass_done), 0);
    rst_n = 1;
    @(negedge clk);
    chk(sub_ready == 1'b1 && disp_valid == '0, "R10 idle after release", int'(disp_valid), 0);

    // Hold cores busy, fill the queues.
    stall = 1;
    for (int p = 1; p <= 4; p++) submit(p, 4, 1);
    repeat (6) @(negedge clk);
    chk(sub_ready == 1'b0, "R1 ready low with queues full", int'(sub_ready), 0);
    chk(n_disp == 4, "R3 no dispatch into busy cores", n_disp, 4);
    for (int i = 0; i < 4; i++)
      chk(first_cores[i] == i, "R7 round-robin start order", first_cores[i], i);
    stall = 0;
    drain();

    // Table walk.
    for (int i = 0; i < NTAB; i++)
      submit(int'(TAB[i][19:16]), int'(TAB[i][15:8]), int'(TAB[i][7:0]));
    drain();

    // Stray done on idle cores, then a fresh job.
    @(negedge clk);
    spur = '1;
    @(negedge clk);
    spur = '0;
    submit(11, 2, 1);
    drain();

    for (int p = 1; p <= 11; p++) begin
      chk(gcnt[p] == exp_geo[p], $sformatf("R2 geo items pass %0d", p), gcnt[p], exp_geo[p]);
      chk(fcnt[p] == exp_frag[p], $sformatf("R2 frag items pass %0d", p), fcnt[p], exp_frag[p]);
    end
    chk(n_done == n_sub, "R8 one completion per job", n_done, n_sub);
    for (int i = 0; i < n_sub; i++)
      chk(done_order[i] == sub_order[i], "R8 completion order", done_order[i], sub_order[i]);
    chk(viol_busy == 0, "R3 busy-core dispatches", viol_busy, 0);
    chk(viol_gate == 0, "R4 early fragment dispatches", viol_gate, 0);
    chk(overlap == 1'b1, "R5 geometry overlapped earlier fragment", int'(overlap), 1);
    chk(viol_rate == 0, "R6 cycles with >1 dispatch per queue", viol_rate, 0);
    chk(gcnt[7] == 0 && done_order[6] == 7, "R11 zero geometry job completes", done_order[6], 7);
    chk(fcnt[8] == 0 && done_order[7] == 8, "R11 zero fragment job completes", done_order[7], 8);
    chk(done_order[n_sub-1] == 11, "R9 job after stray done completes", done_order[n_sub-1], 11);
    summary();
  end
endmodule